// File: doc/BRIEF.md
# Dual-Clip Video Playback Sequencer

This block paces video playback out of an external frame store. Software fills two clip descriptors, each holding a base address, a frame count and a loop count. It sets a frame period in clock cycles and then writes a control word that starts playback. On every frame boundary the sequencer emits a one-cycle load strobe together with the byte address of the frame to fetch. A separate fetch engine reads the frame and forwards it to the display path.

Several control bits decide the play order. A clip can be looped, the two clips can alternate, and the whole set can be repeated. When the set ends, the block either keeps re-issuing the final frame or parks the display. It raises one-cycle pulses when a pass through a clip ends and when all passes of a clip end. A stop bit overrides everything else and parks the display. If a play command names a clip whose descriptor is unusable, the command is refused and an error flag is latched.

Top module: `vid_seq_top`

## Requirements
- R1: After reset: control reads 0x10 (repeat on), period reads 1600000, each clip config reads 0x00010001 (frame count 1 in bits 11:0, loop count 1 in bits 27:16), status reads 0, `park` is 1 and `busy` is 0.
- R2: Register word addresses: 0 control, 1 status (read only), 2 period (bits 23:0), 4/5 clip 0 start/config, 6/7 clip 1 start/config. Read data appears one cycle after the address. The play bit always reads 0. Status bit 0 is busy, bit 1 is the current clip, bit 2 is the abort error.
- R3: Control bits: 0 play, 1 stop, 2 auto-park, 3 first clip, 4 repeat, 5 alternate. Suppose a control write has play=1 and stop=0 and the selected clip is valid. Then, two cycles after the write edge, `busy`=1, `park`=0, `cur_clip` equals bit 3, and `frame_req` is high with that clip's start address.
- R4: Frame n of a pass is requested at start + n*FRAME_BYTES. Consecutive requests within one playback are exactly one period apart.
- R5: `loop_done` pulses once at the end of each pass, and the next pass starts again at the start address.
- R6: `clip_done` pulses once, together with the final `loop_done` of a clip's last pass.
- R7: With auto-park 0, once the sequence ends `busy` drops, `park` stays 0, and the last frame address is re-requested every period.
- R8: With auto-park 1, once the sequence ends `busy` drops, `park` rises, and no further requests are made.
- R9: With alternate set, finishing the first clip's loops switches to the other clip and `cur_clip` follows. Without repeat, the sequence ends after the second clip.
- R10: With repeat set, the sequence restarts on its own (the same clip, or both clips in turn when alternate is set) until stopped.
- R11: Setting stop parks the display within two cycles and ends all requests. A play command written together with stop=1 has no effect.
- R12: A play command for a clip with a zero frame count or loop count does not start playback and sets `abort_err`. The next accepted play clears the flag. Switching into such a clip during alternation also aborts and parks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| frame_req | output | 1 | One-cycle frame load strobe |
| frame_addr | output | 32 | Byte address of the requested frame |
| loop_done | output | 1 | Pass-complete pulse |
| clip_done | output | 1 | Clip-complete pulse |
| park | output | 1 | Display park request |
| busy | output | 1 | Video in progress |
| cur_clip | output | 1 | Clip currently selected |
| abort_err | output | 1 | Sequence abort error flag |

## Verification
The bench targets the points where a pass or clip boundary coincides with the next frame. A design that lets the address keep stepping past the last frame, instead of reloading the start address, would request out-of-clip addresses. A design that drops or doubles the pass and clip pulses would produce event counts that disagree with the loop settings. Alternation is run starting from clip 1 so that a sequencer which ignores the start selection or never switches clips is exposed. The end of a sequence is checked both in hold mode, where a wrong design would go silent or park, and in park mode, where it would keep fetching. The bench also covers refused play commands (zero counts, or stop set together with play), which a lax design would start anyway or leave with a stale error flag.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int NCLIP    = 2;
  localparam int RA_CTRL  = 0;
  localparam int RA_STAT  = 1;
  localparam int RA_PER   = 2;
  localparam int RA_CLIP0 = 4;
  localparam int LOOP_LSB = 16;
  localparam int CB_PLAY  = 0;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HOLD = 2'd2
  } sq_state_t;

  typedef struct packed {
    logic alt;
    logic rpt;
    logic sel;
    logic autostop;
    logic stop;
  } ctrl_t;
endpackage

// File: rtl/vseq_timer.sv
module vseq_timer #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign tick    = run && !restart && (cnt_inc >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_inc[PER_W-1:0];
    end
  end
endmodule

// File: rtl/vseq_regs.sv
module vseq_regs
  import vseq_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                CNT_W   = 12,
  parameter int                PER_W   = 24,
  parameter logic [PER_W-1:0]  PER_RST = 24'd1600000,
  parameter int                RA_W    = 3,
  parameter int                DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [RA_W-1:0]               addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  input  logic                          st_busy,
  input  logic                          st_clip,
  input  logic                          st_err,
  output ctrl_t                         ctrl,
  output logic                          play_pulse,
  output logic [PER_W-1:0]              period,
  output logic [NCLIP-1:0][ADDR_W-1:0]  clip_start,
  output logic [NCLIP-1:0][CNT_W-1:0]   clip_frames,
  output logic [NCLIP-1:0][CNT_W-1:0]   clip_loops
);
  localparam logic [RA_W-1:0] A_CTRL = RA_W'(RA_CTRL);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(RA_STAT);
  localparam logic [RA_W-1:0] A_PER  = RA_W'(RA_PER);

  ctrl_t             ctrl_q;
  logic              play_q;
  logic [PER_W-1:0]  per_q;
  logic [DATA_W-1:0] rd_d;
  logic              ctrl_hit;
  logic              per_hit;

  assign ctrl_hit   = we && (addr == A_CTRL);
  assign per_hit    = we && (addr == A_PER);
  assign ctrl       = ctrl_q;
  assign play_pulse = play_q;
  assign period     = per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.alt      <= 1'b0;
      ctrl_q.rpt      <= 1'b1;
      ctrl_q.sel      <= 1'b0;
      ctrl_q.autostop <= 1'b0;
      ctrl_q.stop     <= 1'b0;
      play_q          <= 1'b0;
      per_q           <= PER_RST;
    end else begin
      play_q <= ctrl_hit && wdata[CB_PLAY];
      if (ctrl_hit) ctrl_q <= ctrl_t'(wdata[5:1]);
      if (per_hit)  per_q  <= wdata[PER_W-1:0];
    end
  end

  for (genvar k = 0; k < NCLIP; k++) begin : g_clip
    localparam logic [RA_W-1:0] A_START = RA_W'(RA_CLIP0 + 2*k);
    localparam logic [RA_W-1:0] A_CFG   = RA_W'(RA_CLIP0 + 2*k + 1);
    logic [ADDR_W-1:0] start_q;
    logic [CNT_W-1:0]  frames_q;
    logic [CNT_W-1:0]  loops_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        start_q  <= '0;
        frames_q <= CNT_W'(1);
        loops_q  <= CNT_W'(1);
      end else if (we && addr == A_START) begin
        start_q <= wdata[ADDR_W-1:0];
      end else if (we && addr == A_CFG) begin
        frames_q <= wdata[CNT_W-1:0];
        loops_q  <= wdata[LOOP_LSB +: CNT_W];
      end
    end

    assign clip_start[k]  = start_q;
    assign clip_frames[k] = frames_q;
    assign clip_loops[k]  = loops_q;
  end

  always_comb begin
    rd_d = '0;
    if (addr == A_CTRL) rd_d[5:1] = ctrl_q;
    if (addr == A_STAT) rd_d[2:0] = {st_err, st_clip, st_busy};
    if (addr == A_PER)  rd_d[PER_W-1:0] = per_q;
    for (int k = 0; k < NCLIP; k++) begin
      if (addr == RA_W'(RA_CLIP0 + 2*k)) rd_d[ADDR_W-1:0] = clip_start[k];
      if (addr == RA_W'(RA_CLIP0 + 2*k + 1)) begin
        rd_d[CNT_W-1:0]          = clip_frames[k];
        rd_d[LOOP_LSB +: CNT_W]  = clip_loops[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/vseq_seq.sv
module vseq_seq
  import vseq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 12,
  parameter int FRAME_BYTES = 4096
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         play_pulse,
  input  ctrl_t                        ctrl,
  input  logic [NCLIP-1:0][ADDR_W-1:0] clip_start,
  input  logic [NCLIP-1:0][CNT_W-1:0]  clip_frames,
  input  logic [NCLIP-1:0][CNT_W-1:0]  clip_loops,
  input  logic                         tick,
  output logic                         timer_run,
  output logic                         timer_restart,
  output logic                         frame_req,
  output logic [ADDR_W-1:0]            frame_addr,
  output logic                         loop_done,
  output logic                         clip_done,
  output logic                         busy,
  output logic                         park,
  output logic                         cur_clip,
  output logic                         abort_err
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FRAME_BYTES);

  sq_state_t         st_q, st_d;
  logic              clip_q, clip_d;
  logic              second_q, second_d;
  logic [CNT_W-1:0]  fidx_q, fidx_d;
  logic [CNT_W-1:0]  lidx_q, lidx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              req_q, req_d;
  logic              ldone_q, ldone_d;
  logic              cdone_q, cdone_d;
  logic              busy_q, busy_d;
  logic              park_q, park_d;
  logic              err_q, err_d;
  logic              go_clip;
  logic              tgt;
  logic              finish;
  logic              last_frame;
  logic              last_loop;
  logic              tgt_ok;

  assign last_frame    = ({1'b0, fidx_q} + 1'b1) >= {1'b0, clip_frames[clip_q]};
  assign last_loop     = ({1'b0, lidx_q} + 1'b1) >= {1'b0, clip_loops[clip_q]};
  assign tgt_ok        = (clip_frames[tgt] != '0) && (clip_loops[tgt] != '0);
  assign timer_run     = (st_q != SQ_IDLE);
  assign timer_restart = play_pulse && !ctrl.stop;

  always_comb begin
    st_d     = st_q;
    clip_d   = clip_q;
    second_d = second_q;
    fidx_d   = fidx_q;
    lidx_d   = lidx_q;
    addr_d   = addr_q;
    req_d    = 1'b0;
    ldone_d  = 1'b0;
    cdone_d  = 1'b0;
    busy_d   = busy_q;
    park_d   = park_q;
    err_d    = err_q;
    go_clip  = 1'b0;
    finish   = 1'b0;
    tgt      = clip_q;

    if (ctrl.stop) begin
      st_d   = SQ_IDLE;
      busy_d = 1'b0;
      park_d = 1'b1;
    end else if (play_pulse) begin
      tgt      = ctrl.sel;
      second_d = 1'b0;
      err_d    = 1'b0;
      go_clip  = 1'b1;
    end else if (tick) begin
      if (st_q == SQ_HOLD) begin
        req_d = 1'b1;
      end else if (st_q == SQ_RUN) begin
        if (!last_frame) begin
          fidx_d = fidx_q + 1'b1;
          addr_d = addr_q + STEP;
          req_d  = 1'b1;
        end else begin
          ldone_d = 1'b1;
          if (!last_loop) begin
            lidx_d = lidx_q + 1'b1;
            fidx_d = '0;
            addr_d = clip_start[clip_q];
            req_d  = 1'b1;
          end else begin
            cdone_d = 1'b1;
            if (ctrl.alt && !second_q) begin
              tgt      = ~clip_q;
              second_d = 1'b1;
              go_clip  = 1'b1;
            end else if (ctrl.rpt) begin
              tgt      = ctrl.alt ? ~clip_q : clip_q;
              second_d = 1'b0;
              go_clip  = 1'b1;
            end else begin
              finish = 1'b1;
            end
          end
        end
      end
    end

    if (go_clip) begin
      if (tgt_ok) begin
        st_d   = SQ_RUN;
        clip_d = tgt;
        fidx_d = '0;
        lidx_d = '0;
        addr_d = clip_start[tgt];
        req_d  = 1'b1;
        busy_d = 1'b1;
        park_d = 1'b0;
      end else begin
        err_d  = 1'b1;
        st_d   = SQ_IDLE;
        busy_d = 1'b0;
        park_d = 1'b1;
        req_d  = 1'b0;
      end
    end

    if (finish) begin
      busy_d = 1'b0;
      if (ctrl.autostop) begin
        st_d   = SQ_IDLE;
        park_d = 1'b1;
      end else begin
        st_d  = SQ_HOLD;
        req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      clip_q   <= 1'b0;
      second_q <= 1'b0;
      fidx_q   <= '0;
      lidx_q   <= '0;
      addr_q   <= '0;
      req_q    <= 1'b0;
      ldone_q  <= 1'b0;
      cdone_q  <= 1'b0;
      busy_q   <= 1'b0;
      park_q   <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      clip_q   <= clip_d;
      second_q <= second_d;
      fidx_q   <= fidx_d;
      lidx_q   <= lidx_d;
      addr_q   <= addr_d;
      req_q    <= req_d;
      ldone_q  <= ldone_d;
      cdone_q  <= cdone_d;
      busy_q   <= busy_d;
      park_q   <= park_d;
      err_q    <= err_d;
    end
  end

  assign frame_req  = req_q;
  assign frame_addr = addr_q;
  assign loop_done  = ldone_q;
  assign clip_done  = cdone_q;
  assign busy       = busy_q;
  assign park       = park_q;
  assign cur_clip   = clip_q;
  assign abort_err  = err_q;
endmodule

// File: rtl/vid_seq_top.sv
module vid_seq_top
  import vseq_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               CNT_W       = 12,
  parameter int               PER_W       = 24,
  parameter logic [PER_W-1:0] PER_RST     = 24'd1600000,
  parameter int               FRAME_BYTES = 4096,
  parameter int               RA_W        = 3,
  parameter int               DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              frame_req,
  output logic [ADDR_W-1:0] frame_addr,
  output logic              loop_done,
  output logic              clip_done,
  output logic              park,
  output logic              busy,
  output logic              cur_clip,
  output logic              abort_err
);
  ctrl_t                        ctrl;
  logic                         play_pulse;
  logic [PER_W-1:0]             period;
  logic [NCLIP-1:0][ADDR_W-1:0] clip_start;
  logic [NCLIP-1:0][CNT_W-1:0]  clip_frames;
  logic [NCLIP-1:0][CNT_W-1:0]  clip_loops;
  logic                         tick;
  logic                         timer_run;
  logic                         timer_restart;

  vseq_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PER_W(PER_W), .PER_RST(PER_RST),
    .RA_W(RA_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .st_busy(busy), .st_clip(cur_clip), .st_err(abort_err),
    .ctrl(ctrl), .play_pulse(play_pulse), .period(period),
    .clip_start(clip_start), .clip_frames(clip_frames), .clip_loops(clip_loops)
  );

  vseq_timer #(.PER_W(PER_W)) i_timer (
    .clk(clk), .rst(rst), .run(timer_run), .restart(timer_restart),
    .period(period), .tick(tick)
  );

  vseq_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_BYTES(FRAME_BYTES)
  ) i_seq (
    .clk(clk), .rst(rst), .play_pulse(play_pulse), .ctrl(ctrl),
    .clip_start(clip_start), .clip_frames(clip_frames), .clip_loops(clip_loops),
    .tick(tick), .timer_run(timer_run), .timer_restart(timer_restart),
    .frame_req(frame_req), .frame_addr(frame_addr), .loop_done(loop_done),
    .clip_done(clip_done), .busy(busy), .park(park), .cur_clip(cur_clip),
    .abort_err(abort_err)
  );
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int RA_W   = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [RA_W-1:0]   reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              frame_req,
  input logic              loop_done,
  input logic              clip_done,
  input logic              park,
  input logic              busy,
  input logic              abort_err
);
  AST_REQ_UNPARKED: assert property (@(posedge clk) disable iff (rst)
    frame_req |-> !park);  // R3
  AST_PARK_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    park |-> !busy);  // R8
  AST_STOP_PARKS: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == '0 && reg_wdata[1]) |=> ##1 park);  // R11
  AST_CLIP_WITH_LOOP: assert property (@(posedge clk) disable iff (rst)
    clip_done |-> loop_done);  // R6
  AST_PASS_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    (loop_done && !park) |-> frame_req);  // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_err) |-> (!busy && park));  // R12
endmodule

bind vid_seq_top vseq_chk #(.RA_W(RA_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .frame_req(frame_req), .loop_done(loop_done),
  .clip_done(clip_done), .park(park), .busy(busy), .abort_err(abort_err)
);

// File: tb/test_vid_seq_top.sv
module test_vid_seq_top;
  localparam int FB  = 4096;
  localparam int PER = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_req, loop_done, clip_done, park, busy, cur_clip, abort_err;
  logic [31:0] frame_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int loops_seen, clips_seen, req_n, gap_last;
  bit hold_ok;
  logic [31:0] hold_addr;
  logic [31:0] exp_q[$];
  logic [31:0] rv;

  always #2 clk = ~clk;

  vid_seq_top i_vid_seq_top (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_req(frame_req),
    .frame_addr(frame_addr), .loop_done(loop_done), .clip_done(clip_done),
    .park(park), .busy(busy), .cur_clip(cur_clip), .abort_err(abort_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      chk(0, "R3", "watchdog expired", cyc, 50000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (loop_done) loops_seen++;
      if (clip_done) clips_seen++;
      if (frame_req) begin
        req_n++;
        if (gap_last >= 0) chk(cyc - gap_last == PER, "R4", "request spacing", cyc - gap_last, PER);
        gap_last = cyc;
        if (exp_q.size() > 0) begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(frame_addr == e, "R4", "frame address", frame_addr, e);
        end else if (hold_ok) begin
          chk(frame_addr == hold_addr, "R7", "held frame address", frame_addr, hold_addr);
        end else begin
          chk(0, "R11", "unexpected frame request", frame_addr, 0);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic new_case();
    loops_seen = 0; clips_seen = 0; req_n = 0; gap_last = -1; hold_ok = 0;
  endtask

  task automatic push_clip(input logic [31:0] s, input int nf, input int nl);
    for (int l = 0; l < nl; l++)
      for (int f = 0; f < nf; f++) exp_q.push_back(s + 32'(f * FB));
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && exp_q.size() > 0; i++) @(posedge clk);
    chk(exp_q.size() == 0, req, "pending expected frames", exp_q.size(), 0);
  endtask

  task automatic after_write();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    new_case();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk(park == 1'b1, "R1", "park after reset", park, 1);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    rd(3'd0, rv); chk(rv == 32'h10, "R1", "control reset", rv, 32'h10);
    rd(3'd2, rv); chk(rv == 32'd1600000, "R1", "period reset", rv, 1600000);
    rd(3'd5, rv); chk(rv == 32'h0001_0001, "R1", "clip0 config reset", rv, 32'h0001_0001);
    rd(3'd1, rv); chk(rv == 32'h0, "R1", "status reset", rv, 0);

    // R2 register access
    wr(3'd2, PER);
    rd(3'd2, rv); chk(rv == PER, "R2", "period readback", rv, PER);

    // single clip, 3 frames x 2 loops, auto-park
    new_case();
    wr(3'd4, 32'h1000_0000);
    wr(3'd5, (32'd2 << 16) | 32'd3);
    rd(3'd5, rv); chk(rv == 32'h0002_0003, "R2", "clip0 config readback", rv, 32'h0002_0003);
    push_clip(32'h1000_0000, 3, 2);
    wr(3'd0, 32'h05);
    after_write();
    chk(busy == 1'b1, "R3", "busy after play", busy, 1);
    chk(park == 1'b0, "R3", "park after play", park, 0);
    rd(3'd0, rv); chk(rv == 32'h04, "R2", "play bit reads zero", rv, 4);
    drain("R4");
    repeat (3 * PER) @(posedge clk);
    @(negedge clk);
    chk(loops_seen == 2, "R5", "pass pulses", loops_seen, 2);
    chk(clips_seen == 1, "R6", "clip pulses", clips_seen, 1);
    chk(park == 1'b1, "R8", "park after finish", park, 1);
    chk(busy == 1'b0, "R8", "busy after finish", busy, 0);

    // alternate from clip 1, hold at end
    new_case();
    wr(3'd5, (32'd3 << 16) | 32'd1);
    wr(3'd6, 32'h2000_0000);
    wr(3'd7, (32'd1 << 16) | 32'd2);
    push_clip(32'h2000_0000, 2, 1);
    push_clip(32'h1000_0000, 1, 3);
    hold_ok = 1; hold_addr = 32'h1000_0000;
    wr(3'd0, 32'h29);
    after_write();
    chk(cur_clip == 1'b1, "R9", "starting clip", cur_clip, 1);
    rd(3'd1, rv); chk(rv == 32'h3, "R2", "status while playing clip 1", rv, 3);
    drain("R9");
    repeat (3 * PER) @(posedge clk);
    @(negedge clk);
    chk(loops_seen == 4, "R5", "pass pulses alternating", loops_seen, 4);
    chk(clips_seen == 2, "R9", "clip pulses alternating", clips_seen, 2);
    chk(cur_clip == 1'b0, "R9", "clip after switch", cur_clip, 0);
    chk(busy == 1'b0, "R7", "busy in hold", busy, 0);
    chk(park == 1'b0, "R7", "park in hold", park, 0);
    chk(req_n >= 6, "R7", "held frames re-requested", req_n, 6);
    wr(3'd0, 32'h02);
    after_write();
    chk(park == 1'b1, "R11", "park after stop", park, 1);
    rv = req_n;
    repeat (3 * PER) @(posedge clk);
    @(negedge clk);
    chk(req_n == int'(rv), "R11", "no requests after stop", req_n, rv);

    // repeat single clip until stopped
    new_case();
    wr(3'd4, 32'h3000_0000);
    wr(3'd5, (32'd1 << 16) | 32'd2);
    for (int i = 0; i < 5; i++) push_clip(32'h3000_0000, 2, 1);
    wr(3'd0, 32'h11);
    drain("R10");
    wr(3'd0, 32'h02);
    repeat (3 * PER) @(posedge clk);
    @(negedge clk);
    chk(loops_seen == 4, "R10", "pass pulses while repeating", loops_seen, 4);
    chk(clips_seen == 4, "R10", "clip pulses while repeating", clips_seen, 4);
    chk(park == 1'b1, "R11", "park after stopping repeat", park, 1);

    // invalid clip refused
    new_case();
    wr(3'd5, 32'h0001_0000);
    wr(3'd0, 32'h05);
    after_write();
    chk(abort_err == 1'b1, "R12", "abort on zero frames", abort_err, 1);
    chk(busy == 1'b0, "R12", "no start on zero frames", busy, 0);
    repeat (3 * PER) @(posedge clk);
    rd(3'd1, rv); chk(rv == 32'h4, "R12", "status error bit", rv, 4);
    chk(req_n == 0, "R12", "no request on refusal", req_n, 0);
    wr(3'd5, 32'h0001_0001);
    push_clip(32'h3000_0000, 1, 1);
    wr(3'd0, 32'h05);
    after_write();
    chk(abort_err == 1'b0, "R12", "error cleared by play", abort_err, 0);
    drain("R12");
    repeat (2 * PER) @(posedge clk);
    @(negedge clk);
    chk(park == 1'b1, "R8", "park after short clip", park, 1);

    // play with stop set is ignored
    new_case();
    wr(3'd0, 32'h03);
    repeat (3 * PER) @(posedge clk);
    @(negedge clk);
    chk(park == 1'b1, "R11", "park kept with stop", park, 1);
    chk(busy == 1'b0, "R11", "no start with stop", busy, 0);
    chk(req_n == 0, "R11", "no request with stop", req_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule